// File: doc/BRIEF.md
# Two-Unit Scheduled Execution Engine

This block is a cycle-level timing engine for a stream of abstract instructions. Each instruction names one of two functional-unit classes, a latency and, optionally, one earlier instruction whose result it needs. The engine accepts at most one instruction per cycle and places it in a small waiting buffer in front of its unit. It starts execution when the unit is free and the producer has finished. A ring of in-flight records then retires the instructions strictly in program order. No data is computed. The outputs are event pulses tagged with the instruction's sequence number, plus a free-running cycle counter, from which issue, finish and completion times can be read.

A waiting-buffer slot stays occupied from dispatch until its instruction has finished executing, not merely until it starts. A buffer that is full of stalled work therefore blocks every later instruction in the stream. Sequence numbers are given out from zero after reset in dispatch order. The instruction flagged as last produces a done pulse that carries the total cycle count.

Top module: `xeng_core`

## Requirements
- R1: `in_ready` is high in a cycle exactly when the waiting buffer of the unit selected by `in_cls` (0 = unit 0, 1 = unit 1) has a free slot and the retirement ring is not full. An instruction is accepted in a cycle where both `in_valid` and `in_ready` are high, at most one per cycle.
- R2: An instruction that arrives while its unit is idle, with its operand ready and no older instruction in that buffer ready, starts (`iss_vld` for its unit) in the cycle it is accepted.
- R3: A unit executes one instruction at a time. An instruction started in cycle t with latency L (a latency of 0 counts as 1) raises `fin_vld` in cycle t+L-1, and the unit can start the next instruction in cycle t+L.
- R4: A buffer slot is released only at the end of its instruction's finish cycle. While all slots of a unit are held, including by instructions that are still waiting to start, later instructions for that unit are not accepted, and neither is anything behind them.
- R5: An instruction with `in_dep_vld` set starts no earlier than the cycle after the instruction numbered `in_dep` finishes.
- R6: An instruction completes (counted in `cmp_num`, starting at `cmp_base`) no earlier than the cycle after it finishes and never before an older instruction. Several instructions may complete in one cycle.
- R7: When several instructions in one buffer are ready for an idle unit, the one with the lowest sequence number starts first.
- R8: One cycle after the instruction accepted with `in_last` completes, `done` pulses for one cycle, and `done_cycles` holds the value `now` had in that completion cycle.
- R9: Out of reset, `now` is 0, `in_ready` is high, and no issue, finish, completion or done event is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered |
| in_cls | input | 1 | Unit class of the offered instruction |
| in_lat | input | 4 | Execution latency in cycles |
| in_dep_vld | input | 1 | Instruction depends on an earlier one |
| in_dep | input | 6 | Sequence number of the producer |
| in_last | input | 1 | Marks the final instruction of the stream |
| in_ready | output | 1 | Offered instruction is accepted this cycle |
| now | output | 16 | Cycles since reset |
| iss_vld | output | 2 | Per-unit start pulse |
| iss_tag | output | 12 | Per-unit sequence number of the starting instruction |
| fin_vld | output | 2 | Per-unit finish pulse |
| fin_tag | output | 12 | Per-unit sequence number of the finishing instruction |
| cmp_num | output | 4 | Number of instructions completing this cycle |
| cmp_base | output | 6 | Sequence number of the first one completing |
| done | output | 1 | Last instruction's completion pulse |
| done_cycles | output | 16 | Cycle of that completion |

## Verification
The assertions assume that every dependency names an instruction that was accepted earlier. They also assume that no more than 64 instructions are accepted between resets, so that sequence-number distances never wrap, and that a new stream begins only after a reset. The stimulus keeps to these limits. It resets before every stream, uses streams of two to four instructions and points each dependency only at instruction 0. Each sweep pairs a first instruction with a second one, crossing same or other unit, with and without a dependency, across latencies 1 to 4. Separate sequences fill a buffer with waiting work to exercise the stall and the oldest-first choice.

// File: rtl/xeng_pkg.sv
package xeng_pkg;
    localparam int LAT_W     = 4;
    localparam int IDX_W     = 6;
    localparam int ROB_SLOTS = 8;
    localparam int ROB_AW    = $clog2(ROB_SLOTS);
    localparam int NUM_FU    = 2;
    localparam int CLS_W     = $clog2(NUM_FU);
    localparam int CNT_W     = $clog2(ROB_SLOTS + 1);

    typedef logic [IDX_W-1:0] seq_t;
    typedef logic [LAT_W-1:0] lat_t;

    typedef struct packed {
        seq_t tag;
        lat_t lat;
        logic has_dep;
        seq_t dep;
    } op_t;

    function automatic lat_t eff_lat(input lat_t l);
        return (l == '0) ? lat_t'(1) : l;
    endfunction

    // Producer counts as done if it left the ring or its finish flag is set.
    function automatic logic src_done(input logic has_dep, input seq_t dep,
                                      input seq_t head, input seq_t tail,
                                      input logic [ROB_SLOTS-1:0] fin);
        seq_t off;
        seq_t occ;
        off = dep - head;
        occ = tail - head;
        if (!has_dep)   return 1'b1;
        if (off >= occ) return 1'b1;
        return fin[dep[ROB_AW-1:0]];
    endfunction
endpackage

// File: rtl/rob_ring.sv
module rob_ring import xeng_pkg::*; (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc,
    input  logic [NUM_FU-1:0]      fin_vld,
    input  seq_t [NUM_FU-1:0]      fin_tag,
    output seq_t                   head,
    output seq_t                   tail,
    output logic [ROB_SLOTS-1:0]   fin_map,
    output logic                   full,
    output logic [CNT_W-1:0]       cmp_num
);
    seq_t occ;
    logic stop;
    seq_t pos;

    assign occ  = tail - head;
    assign full = (occ == seq_t'(ROB_SLOTS));

    always_comb begin
        cmp_num = '0;
        stop    = 1'b0;
        pos     = '0;
        for (int k = 0; k < ROB_SLOTS; k++) begin
            pos = head + seq_t'(k);
            if (!stop && (seq_t'(k) < occ) && fin_map[pos[ROB_AW-1:0]])
                cmp_num = cmp_num + CNT_W'(1);
            else
                stop = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head    <= '0;
            tail    <= '0;
            fin_map <= '0;
        end else begin
            head <= head + seq_t'(cmp_num);
            for (int k = 0; k < ROB_SLOTS; k++) begin
                if (CNT_W'(k) < cmp_num)
                    fin_map[ROB_AW'(head + seq_t'(k))] <= 1'b0;
            end
            if (alloc) begin
                fin_map[tail[ROB_AW-1:0]] <= 1'b0;
                tail <= tail + seq_t'(1);
            end
            for (int f = 0; f < NUM_FU; f++) begin
                if (fin_vld[f])
                    fin_map[fin_tag[f][ROB_AW-1:0]] <= 1'b1;
            end
        end
    end

    a_r1_no_alloc_when_full: assert property (@(posedge clk) disable iff (rst)
        alloc |-> !full);
    a_r1_occ_bound: assert property (@(posedge clk) disable iff (rst)
        occ <= seq_t'(ROB_SLOTS));
    a_r6_commit_within_occ: assert property (@(posedge clk) disable iff (rst)
        seq_t'(cmp_num) <= occ);
endmodule

// File: rtl/fu_slot.sv
module fu_slot import xeng_pkg::*; #(
    parameter int RS_DEPTH = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  disp_en,
    input  op_t                   disp_op,
    input  seq_t                  head,
    input  seq_t                  tail,
    input  logic [ROB_SLOTS-1:0]  fin_map,
    output logic                  has_room,
    output logic                  iss_vld,
    output seq_t                  iss_tag,
    output logic                  fin_vld,
    output seq_t                  fin_tag
);
    localparam int RS_AW = (RS_DEPTH > 1) ? $clog2(RS_DEPTH) : 1;

    logic [RS_DEPTH-1:0] ent_vld;
    logic [RS_DEPTH-1:0] ent_iss;
    op_t                 ent_op [RS_DEPTH];
    logic                busy_q;
    lat_t                left_q;
    logic [RS_AW-1:0]    cur_slot;
    seq_t                cur_tag;

    logic             pick_vld, free_vld, rs_go, in_go;
    logic [RS_AW-1:0] pick_slot, free_slot;
    seq_t             best_age, age;
    op_t              iss_op;
    lat_t             iss_lat;

    always_comb begin
        pick_vld  = 1'b0;
        pick_slot = '0;
        best_age  = '1;
        age       = '0;
        free_vld  = 1'b0;
        free_slot = '0;
        for (int i = 0; i < RS_DEPTH; i++) begin
            age = ent_op[i].tag - head;
            if (ent_vld[i] && !ent_iss[i] &&
                src_done(ent_op[i].has_dep, ent_op[i].dep, head, tail, fin_map) &&
                (!pick_vld || age < best_age)) begin
                pick_vld  = 1'b1;
                pick_slot = RS_AW'(i);
                best_age  = age;
            end
            if (!ent_vld[i] && !free_vld) begin
                free_vld  = 1'b1;
                free_slot = RS_AW'(i);
            end
        end
    end

    assign rs_go    = !busy_q && pick_vld;
    assign in_go    = disp_en && !busy_q && !pick_vld &&
                      src_done(disp_op.has_dep, disp_op.dep, head, tail, fin_map);
    assign iss_vld  = rs_go || in_go;
    assign iss_op   = rs_go ? ent_op[pick_slot] : disp_op;
    assign iss_lat  = eff_lat(iss_op.lat);
    assign iss_tag  = iss_op.tag;
    assign fin_vld  = (busy_q && left_q == lat_t'(1)) || (iss_vld && iss_lat == lat_t'(1));
    assign fin_tag  = busy_q ? cur_tag : iss_op.tag;
    assign has_room = free_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_vld  <= '0;
            ent_iss  <= '0;
            busy_q   <= 1'b0;
            left_q   <= '0;
            cur_slot <= '0;
            cur_tag  <= '0;
            for (int i = 0; i < RS_DEPTH; i++) ent_op[i] <= '0;
        end else begin
            if (busy_q) begin
                if (left_q == lat_t'(1)) begin
                    busy_q            <= 1'b0;
                    ent_vld[cur_slot] <= 1'b0;
                end else begin
                    left_q <= left_q - lat_t'(1);
                end
            end
            if (rs_go) begin
                ent_iss[pick_slot] <= 1'b1;
                if (iss_lat == lat_t'(1)) begin
                    ent_vld[pick_slot] <= 1'b0;
                end else begin
                    busy_q   <= 1'b1;
                    left_q   <= iss_lat - lat_t'(1);
                    cur_slot <= pick_slot;
                    cur_tag  <= iss_op.tag;
                end
            end
            if (disp_en) begin
                if (!(in_go && iss_lat == lat_t'(1))) begin
                    ent_vld[free_slot] <= 1'b1;
                    ent_iss[free_slot] <= in_go;
                    ent_op[free_slot]  <= disp_op;
                end
                if (in_go && iss_lat != lat_t'(1)) begin
                    busy_q   <= 1'b1;
                    left_q   <= iss_lat - lat_t'(1);
                    cur_slot <= free_slot;
                    cur_tag  <= disp_op.tag;
                end
            end
        end
    end

    a_r3_finish_frees_unit: assert property (@(posedge clk) disable iff (rst)
        fin_vld |=> !busy_q);
    a_r3_count_nonzero: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> left_q != '0);
    a_r4_slot_held: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> ent_vld[cur_slot]);
    a_r1_room_on_disp: assert property (@(posedge clk) disable iff (rst)
        disp_en |-> has_room);
endmodule

// File: rtl/xeng_core.sv
module xeng_core import xeng_pkg::*; #(
    parameter int RS_DEPTH = 1,
    parameter int CYC_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [CLS_W-1:0]        in_cls,
    input  logic [LAT_W-1:0]        in_lat,
    input  logic                    in_dep_vld,
    input  logic [IDX_W-1:0]        in_dep,
    input  logic                    in_last,
    output logic                    in_ready,
    output logic [CYC_W-1:0]        now,
    output logic [NUM_FU-1:0]       iss_vld,
    output logic [NUM_FU*IDX_W-1:0] iss_tag,
    output logic [NUM_FU-1:0]       fin_vld,
    output logic [NUM_FU*IDX_W-1:0] fin_tag,
    output logic [CNT_W-1:0]        cmp_num,
    output logic [IDX_W-1:0]        cmp_base,
    output logic                    done,
    output logic [CYC_W-1:0]        done_cycles
);
    seq_t                 head, tail;
    logic [ROB_SLOTS-1:0] fin_map;
    logic                 rob_full;
    logic [NUM_FU-1:0]    room;
    seq_t [NUM_FU-1:0]    fin_tags;
    logic                 fire;
    op_t                  in_op;
    logic                 last_vld_q;
    seq_t                 last_q;
    logic                 last_hit;

    assign in_ready = !rob_full && room[in_cls];
    assign fire     = in_valid && in_ready;
    assign in_op    = '{tag: tail, lat: in_lat, has_dep: in_dep_vld, dep: in_dep};
    assign cmp_base = head;

    for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
        seq_t it, ft;
        fu_slot #(.RS_DEPTH(RS_DEPTH)) u_fu (
            .clk      (clk),
            .rst      (rst),
            .disp_en  (fire && (in_cls == CLS_W'(u))),
            .disp_op  (in_op),
            .head     (head),
            .tail     (tail),
            .fin_map  (fin_map),
            .has_room (room[u]),
            .iss_vld  (iss_vld[u]),
            .iss_tag  (it),
            .fin_vld  (fin_vld[u]),
            .fin_tag  (ft)
        );
        assign iss_tag[u*IDX_W +: IDX_W] = it;
        assign fin_tag[u*IDX_W +: IDX_W] = ft;
        assign fin_tags[u]               = ft;
    end

    rob_ring u_rob (
        .clk     (clk),
        .rst     (rst),
        .alloc   (fire),
        .fin_vld (fin_vld),
        .fin_tag (fin_tags),
        .head    (head),
        .tail    (tail),
        .fin_map (fin_map),
        .full    (rob_full),
        .cmp_num (cmp_num)
    );

    assign last_hit = last_vld_q && (seq_t'(last_q - head) < seq_t'(cmp_num));

    always_ff @(posedge clk) begin
        if (rst) begin
            now         <= '0;
            last_vld_q  <= 1'b0;
            last_q      <= '0;
            done        <= 1'b0;
            done_cycles <= '0;
        end else begin
            now  <= now + CYC_W'(1);
            done <= last_hit;
            if (last_hit) begin
                done_cycles <= now;
                last_vld_q  <= 1'b0;
            end
            if (fire && in_last) begin
                last_vld_q <= 1'b1;
                last_q     <= tail;
            end
        end
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_done_follows_commit: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(cmp_num) != '0);
endmodule

// File: tb/tb_xeng_core.sv
module tb_xeng_core;
    import xeng_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [CLS_W-1:0] in_cls = '0;
    logic [LAT_W-1:0] in_lat = '0;
    logic in_dep_vld = 1'b0;
    logic [IDX_W-1:0] in_dep = '0;
    logic in_last = 1'b0;
    logic in_ready;
    logic [15:0] now;
    logic [NUM_FU-1:0] iss_vld, fin_vld;
    logic [NUM_FU*IDX_W-1:0] iss_tag, fin_tag;
    logic [CNT_W-1:0] cmp_num;
    logic [IDX_W-1:0] cmp_base;
    logic done;
    logic [15:0] done_cycles;

    always #2 clk = ~clk;

    xeng_core #(.RS_DEPTH(2)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls), .in_lat(in_lat),
        .in_dep_vld(in_dep_vld), .in_dep(in_dep), .in_last(in_last), .in_ready(in_ready),
        .now(now), .iss_vld(iss_vld), .iss_tag(iss_tag), .fin_vld(fin_vld), .fin_tag(fin_tag),
        .cmp_num(cmp_num), .cmp_base(cmp_base), .done(done), .done_cycles(done_cycles)
    );

    int nchk = 0, nerr = 0;
    int q_cls[4], q_lat[4], q_dv[4], q_dep[4];
    int n_ins;
    int t_disp[4], t_iss[4], t_fin[4], t_cmp[4];
    int t_done;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_seq();
        int ptr;
        rst = 1'b1; in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ptr = 0; t_done = -1;
        for (int i = 0; i < 4; i++) begin
            t_disp[i] = -1; t_iss[i] = -1; t_fin[i] = -1; t_cmp[i] = -1;
        end
        for (int cyc = 0; cyc < 60 && t_done < 0; cyc++) begin
            if (ptr < n_ins) begin
                in_valid   = 1'b1;
                in_cls     = CLS_W'(q_cls[ptr]);
                in_lat     = LAT_W'(q_lat[ptr]);
                in_dep_vld = q_dv[ptr] != 0;
                in_dep     = IDX_W'(q_dep[ptr]);
                in_last    = (ptr == n_ins - 1);
            end else begin
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
            #1;
            for (int u = 0; u < NUM_FU; u++) begin
                int ti, tf;
                ti = int'(iss_tag[u*IDX_W +: IDX_W]);
                tf = int'(fin_tag[u*IDX_W +: IDX_W]);
                if (iss_vld[u] && ti < 4) t_iss[ti] = int'(now);
                if (fin_vld[u] && tf < 4) t_fin[tf] = int'(now);
            end
            for (int k = 0; k < int'(cmp_num); k++) begin
                int tc;
                tc = int'(cmp_base) + k;
                if (tc < 4) t_cmp[tc] = int'(now);
            end
            if (in_valid && in_ready) begin
                t_disp[ptr] = int'(now);
                ptr++;
            end
            if (done) t_done = int'(done_cycles);
            @(negedge clk);
        end
        in_valid = 1'b0;
        if (t_done < 0) chk("R8 watchdog", 0, 1);
    endtask

    initial begin
        // R9 reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 now", int'(now), 0);
        chk("R1 R9 ready", int'(in_ready), 1);
        chk("R9 iss", int'(iss_vld), 0);
        chk("R9 fin", int'(fin_vld), 0);
        chk("R9 cmp", int'(cmp_num), 0);
        chk("R9 done", int'(done), 0);

        // Pair sweep
        for (int same = 0; same < 2; same++)
        for (int dv = 0; dv < 2; dv++)
        for (int la = 1; la <= 4; la++)
        for (int lb = 1; lb <= 4; lb++) begin
            int biss, bfin, bcmp;
            n_ins = 2;
            q_cls[0] = 0; q_lat[0] = la; q_dv[0] = 0; q_dep[0] = 0;
            q_cls[1] = same ? 0 : 1; q_lat[1] = lb; q_dv[1] = dv; q_dep[1] = 0;
            run_seq();
            biss = (same != 0 || dv != 0) ? la : 1;
            bfin = biss + lb - 1;
            bcmp = (bfin + 1 > la) ? bfin + 1 : la;
            chk("R2 A issue", t_iss[0], 0);
            chk("R3 A finish", t_fin[0], la - 1);
            chk("R6 A complete", t_cmp[0], la);
            chk("R1 B dispatch", t_disp[1], 1);
            if (same != 0)   chk("R3 B issue after unit frees", t_iss[1], biss);
            else if (dv != 0) chk("R5 B issue after producer", t_iss[1], biss);
            else             chk("R2 B issue on dispatch", t_iss[1], biss);
            chk("R3 B finish", t_fin[1], bfin);
            chk("R6 B complete in order", t_cmp[1], bcmp);
            chk("R8 done cycles", t_done, bcmp);
        end

        // Buffer full of waiting work, oldest-first choice
        n_ins = 4;
        q_cls[0] = 0; q_lat[0] = 3; q_dv[0] = 0; q_dep[0] = 0;
        q_cls[1] = 1; q_lat[1] = 1; q_dv[1] = 1; q_dep[1] = 0;
        q_cls[2] = 1; q_lat[2] = 1; q_dv[2] = 1; q_dep[2] = 0;
        q_cls[3] = 1; q_lat[3] = 1; q_dv[3] = 0; q_dep[3] = 0;
        run_seq();
        chk("R1 C dispatch", t_disp[2], 2);
        chk("R4 D stalls until slot freed", t_disp[3], 4);
        chk("R5 B waits on A", t_iss[1], 3);
        chk("R7 oldest B before C", t_iss[2], 4);
        chk("R7 D after C", t_iss[3], 5);
        chk("R6 A complete", t_cmp[0], 3);
        chk("R6 B complete", t_cmp[1], 4);
        chk("R6 C complete", t_cmp[2], 5);
        chk("R6 D complete", t_cmp[3], 6);
        chk("R8 done cycles", t_done, 6);

        // Zero latency counts as one
        n_ins = 2;
        q_cls[0] = 0; q_lat[0] = 0; q_dv[0] = 0; q_dep[0] = 0;
        q_cls[1] = 0; q_lat[1] = 2; q_dv[1] = 1; q_dep[1] = 0;
        run_seq();
        chk("R3 zero latency finish", t_fin[0], 0);
        chk("R5 dependent issue", t_iss[1], 1);
        chk("R6 last complete", t_cmp[1], 3);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule